// File: doc/BRIEF.md
# Transmit Address Overlay for a Chip-to-Chip Link

This block sits on the transmit side of a chip-to-chip link, between the local bus slave port and the outbound command path. A local master issues a read or write into a fixed 256 MB outbound window whose upper nibble is 4. The block turns that address, the master's 4-bit privilege index and its security flag into the 32-bit address word that travels to the remote device.

The address is first trimmed by a keep-mask chosen through a configuration field. Then the privilege index and, when enabled, the security flag are written into bit positions chosen by two more fields. Those positions may fall on bits that would otherwise carry address, so one word carries both routing and identity information. The remote side later decodes these fields.

Requests outside the window are not forwarded. They get a one-cycle error pulse instead. Accepted words leave through a single registered valid/ready stage. Results come out strictly in acceptance order.

Top module: `hlo_tx_overlay`

## Requirements
- R1: After synchronous reset `out_valid` and `err_valid` are 0 and `in_ready` is 1.
- R2: A request is in the window when `in_addr[31:28]` equals 4. An accepted request outside the window produces no word; `err_valid` is high for exactly the one cycle after its acceptance.
- R3: Let K be `cfg_overlay[11:8]`. Before overlay, the word holds `in_addr & (2^(K+17) - 1)`. K=15 keeps all 32 bits.
- R4: Let P be `cfg_overlay[3:0]`. P=0 inserts no privilege field. Otherwise privilege bit i replaces word bit P+16+i, for i from 0 to 3. Any such bit above 31 is dropped.
- R5: Let S be `cfg_overlay[7:4]`. S=0 inserts no security bit. Otherwise word bit S+16 carries `in_secure`, and it wins over a privilege bit at the same position.
- R6: With K=11, P=12, S=0, privilege 5 and address 0x4567_89A0, the word is 0x5567_89A0.
- R7: A request is accepted when `in_valid` and `in_ready` are both high, with `in_ready = !out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_word` holds its value, even if the configuration or inputs change.
- R8: Each accepted request yields exactly one result, either a word or an error, and results appear in acceptance order.
- R9: The word appears on `out_word` with `out_valid` high in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request this cycle |
| in_addr | input | 32 | Local bus address of the request |
| in_priv | input | 4 | Privilege index of the issuing master |
| in_secure | input | 1 | Security flag of the request |
| cfg_overlay | input | 12 | {keep select K, security position S, privilege position P} |
| out_valid | output | 1 | Address word available |
| out_ready | input | 1 | Downstream takes the word |
| out_word | output | 32 | Overlaid address word |
| err_valid | output | 1 | One-cycle pulse for an out-of-window request |

## Verification
The assertions assume that `cfg_overlay`, `in_addr`, `in_priv` and `in_secure` are meaningful only in a cycle where a request is accepted. They also assume `out_ready` may change freely on any cycle. The bench changes request inputs and configuration only on the falling clock edge. It presents a new request only after the previous one was taken. It deliberately alters the configuration and the inputs while the output stage is stalled, to show that nothing held is disturbed. The `out_ready` pattern is a deterministic stall rhythm, so both the pass-through and the blocked case of the handshake are reached.

// File: rtl/hlo_pkg.sv
package hlo_pkg;

    localparam int ADDR_W     = 32;
    localparam int PRIV_W     = 4;
    localparam int WIN_W      = 28;
    localparam int TAG_W      = ADDR_W - WIN_W;
    localparam int SEL_W      = 4;
    localparam int CFG_W      = 3 * SEL_W;
    localparam int FIELD_BASE = 16;
    localparam int KEEP_BASE  = 17;
    localparam logic [TAG_W-1:0] WIN_TAG = TAG_W'(4);

    typedef struct packed {
        logic [SEL_W-1:0] keep_sel;
        logic [SEL_W-1:0] sec_pos;
        logic [SEL_W-1:0] priv_pos;
    } ovl_cfg_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [PRIV_W-1:0] priv;
        logic              secure;
    } tx_req_t;

    typedef enum logic [1:0] {
        RES_NONE = 2'd0,
        RES_WORD = 2'd1,
        RES_ERR  = 2'd2
    } res_kind_e;

    function automatic logic bit_kept(input int b, input logic [SEL_W-1:0] k);
        return b < (int'(k) + KEEP_BASE);
    endfunction

    function automatic logic priv_covers(input int b, input logic [SEL_W-1:0] p);
        int lo;
        lo = int'(p) + FIELD_BASE;
        return (p != '0) && (b >= lo) && (b < lo + PRIV_W);
    endfunction

    function automatic logic sec_covers(input int b, input logic [SEL_W-1:0] s);
        return (s != '0) && (b == int'(s) + FIELD_BASE);
    endfunction

    function automatic logic priv_pick(input int b, input logic [SEL_W-1:0] p,
                                       input logic [PRIV_W-1:0] priv);
        logic [PRIV_W-1:0] sh;
        sh = priv >> (b - (int'(p) + FIELD_BASE));
        return sh[0];
    endfunction

endpackage

// File: rtl/hlo_window_check.sv
module hlo_window_check #(
    parameter int ADDR_W = 32,
    parameter int WIN_W  = 28,
    parameter logic [ADDR_W-WIN_W-1:0] TAG = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_win
);
    localparam int TAG_W = ADDR_W - WIN_W;
    logic [TAG_W-1:0] upper;
    assign upper  = addr[ADDR_W-1:WIN_W];
    assign in_win = (upper == TAG);
endmodule

// File: rtl/hlo_overlay_build.sv
module hlo_overlay_build
    import hlo_pkg::*;
(
    input  tx_req_t           req,
    input  ovl_cfg_t          cfg,
    output logic [ADDR_W-1:0] word
);
    for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
        logic from_sec, from_priv, from_addr;
        assign from_sec  = sec_covers(b, cfg.sec_pos);
        assign from_priv = priv_covers(b, cfg.priv_pos);
        assign from_addr = bit_kept(b, cfg.keep_sel);
        assign word[b] = from_sec  ? req.secure :
                         from_priv ? priv_pick(b, cfg.priv_pos, req.priv) :
                         from_addr ? req.addr[b] : 1'b0;
    end
endmodule

// File: rtl/hlo_out_stage.sv
module hlo_out_stage #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         take_word,
    input  logic         take_err,
    input  logic [W-1:0] word_in,
    output logic         in_ready,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_word,
    output logic         err_valid
);
    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= '0;
            err_valid <= 1'b0;
        end else begin
            err_valid <= take_err;
            if (take_word) begin
                out_valid <= 1'b1;
                out_word  <= word_in;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/hlo_tx_overlay.sv
module hlo_tx_overlay
    import hlo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [PRIV_W-1:0] in_priv,
    input  logic              in_secure,
    input  logic [CFG_W-1:0]  cfg_overlay,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_word,
    output logic              err_valid
);
    tx_req_t           req;
    ovl_cfg_t          cfg;
    logic              in_win;
    logic [ADDR_W-1:0] built;
    res_kind_e         kind;

    assign req = '{addr: in_addr, priv: in_priv, secure: in_secure};
    assign cfg = ovl_cfg_t'(cfg_overlay);

    hlo_window_check #(.ADDR_W(ADDR_W), .WIN_W(WIN_W), .TAG(WIN_TAG)) u_win (
        .addr   (in_addr),
        .in_win (in_win)
    );

    hlo_overlay_build u_build (
        .req  (req),
        .cfg  (cfg),
        .word (built)
    );

    always_comb begin
        kind = RES_NONE;
        if (in_valid && in_ready) kind = in_win ? RES_WORD : RES_ERR;
    end

    hlo_out_stage #(.W(ADDR_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .take_word (kind == RES_WORD),
        .take_err  (kind == RES_ERR),
        .word_in   (built),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_word  (out_word),
        .err_valid (err_valid)
    );
endmodule

// File: rtl/hlo_tx_overlay_chk.sv
module hlo_tx_overlay_chk
    import hlo_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [ADDR_W-1:0] in_addr,
    input logic [PRIV_W-1:0] in_priv,
    input logic              in_secure,
    input logic [CFG_W-1:0]  cfg_overlay,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] out_word,
    input logic              err_valid
);
    logic acc, acc_in, acc_out, sec_acc_q, sec_q;
    logic [4:0] sec_idx_q;

    assign acc     = in_valid && in_ready;
    assign acc_in  = acc && (in_addr[ADDR_W-1:WIN_W] == WIN_TAG);
    assign acc_out = acc && (in_addr[ADDR_W-1:WIN_W] != WIN_TAG);

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_acc_q <= 1'b0;
            sec_q     <= 1'b0;
            sec_idx_q <= '0;
        end else begin
            sec_acc_q <= acc_in && (cfg_overlay[7:4] != 4'd0);
            sec_q     <= in_secure;
            sec_idx_q <= 5'(cfg_overlay[7:4]) + 5'd16;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !err_valid));

    p_err_after_reject_r2: assert property (@(posedge clk) disable iff (rst)
        acc_out |=> err_valid);

    p_err_has_cause_r2: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> $past(acc_out));

    p_sec_bit_r5: assert property (@(posedge clk) disable iff (rst)
        sec_acc_q |-> (out_word[sec_idx_q] == sec_q));

    p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

    p_block_when_full_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    p_word_next_cycle_r9: assert property (@(posedge clk) disable iff (rst)
        acc_in |=> out_valid);
endmodule

bind hlo_tx_overlay hlo_tx_overlay_chk u_chk (.*);

// File: tb/test_hlo_tx_overlay.sv
`timescale 1ns/1ps
module test_hlo_tx_overlay;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_addr = '0;
    logic [3:0]  in_priv = '0;
    logic        in_secure = 1'b0;
    logic [11:0] cfg_overlay = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_word;
    logic        err_valid;

    always #2.5 clk = ~clk;

    hlo_tx_overlay i_hlo_tx_overlay (.*);

    int n_checks = 0;
    int n_fail = 0;
    bit          exp_err[$];
    logic [31:0] exp_val[$];
    string       exp_tag[$];
    bit hold_off = 1'b1;
    int rdy_cnt = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // expected word from the requirement text (R3, R4, R5)
    function automatic logic [31:0] model(input logic [31:0] a, input logic [3:0] p,
                                          input logic s, input logic [11:0] c);
        logic [31:0] w;
        int k, pp, ss;
        k = int'(c[11:8]); ss = int'(c[7:4]); pp = int'(c[3:0]);
        w = '0;
        for (int b = 0; b < 32; b++) if (b < k + 17) w[b] = a[b];
        if (pp != 0)
            for (int i = 0; i < 4; i++) if (pp + 16 + i < 32) w[pp + 16 + i] = p[i];
        if (ss != 0) w[ss + 16] = s;
        return w;
    endfunction

    always @(negedge clk) begin
        rdy_cnt++;
        out_ready <= hold_off ? 1'b0 : (rdy_cnt % 3 != 0);
    end

    // monitor: pops expected results as they appear (R8)
    always @(negedge clk) begin
        #2;
        if (!rst) begin
            if (out_valid && out_ready) begin
                if (exp_val.size() == 0) check(0, "R8 unexpected word", out_word, 32'h0);
                else begin
                    check(!exp_err[0] && out_word == exp_val[0], exp_tag[0], out_word,
                          exp_err[0] ? 32'hEEEEEEEE : exp_val[0]);
                    void'(exp_err.pop_front()); void'(exp_val.pop_front());
                    void'(exp_tag.pop_front());
                end
            end
            if (err_valid) begin
                if (exp_val.size() == 0) check(0, "R8 unexpected error", 32'h1, 32'h0);
                else begin
                    check(exp_err[0], exp_tag[0], 32'hEEEEEEEE, exp_val[0]);
                    void'(exp_err.pop_front()); void'(exp_val.pop_front());
                    void'(exp_tag.pop_front());
                end
            end
        end
    end

    task automatic send(input logic [31:0] a, input logic [3:0] p, input logic s,
                        input logic [11:0] c, input string tag);
        @(negedge clk);
        in_addr = a; in_priv = p; in_secure = s; cfg_overlay = c; in_valid = 1'b1;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        exp_err.push_back(a[31:28] != 4'h4);
        exp_val.push_back((a[31:28] != 4'h4) ? 32'hEEEEEEEE : model(a, p, s, c));
        exp_tag.push_back(tag);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 200 && exp_val.size() != 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        check(exp_val.size() == 0, "R8 results outstanding", 32'(exp_val.size()), 32'h0);
    endtask

    initial begin
        fork
            begin
                repeat (4) @(negedge clk);
                rst = 1'b0;
                @(negedge clk); #2;
                check(!out_valid, "R1 out_valid after reset", 32'(out_valid), 32'h0);
                check(!err_valid, "R1 err_valid after reset", 32'(err_valid), 32'h0);
                check(in_ready, "R1 in_ready after reset", 32'(in_ready), 32'h1);
                hold_off = 1'b0;

                send(32'h4567_89A0, 4'h5, 1'b0, {4'd11, 4'd0, 4'd12}, "R6 worked example");
                check(model(32'h4567_89A0, 4'h5, 1'b0, {4'd11, 4'd0, 4'd12}) == 32'h5567_89A0,
                      "R6 model constant", 32'h5567_89A0, 32'h5567_89A0);
                send(32'h4ABC_DEF1, 4'h0, 1'b0, {4'd0, 4'd0, 4'd0}, "R3 keep K=0");
                send(32'h4FFF_FFFF, 4'h0, 1'b1, {4'd15, 4'd0, 4'd0}, "R3 keep K=15");
                send(32'h4123_4567, 4'h9, 1'b1, {4'd7, 4'd0, 4'd0}, "R3 keep K=7");
                send(32'h4FFF_FFFF, 4'hA, 1'b0, {4'd11, 4'd0, 4'd1}, "R4 priv P=1");
                send(32'h4000_0000, 4'h3, 1'b0, {4'd15, 4'd0, 4'd14}, "R4 priv P=14 truncated");
                send(32'h4765_4321, 4'h5, 1'b1, {4'd11, 4'd15, 4'd12}, "R5 sec S=15 over priv");
                send(32'h4FFF_FFFF, 4'hF, 1'b0, {4'd11, 4'd13, 4'd12}, "R5 sec S=13 clears bit");
                send(32'h3FFF_FFFF, 4'h1, 1'b0, {4'd11, 4'd0, 4'd12}, "R2 below window");
                send(32'h5000_0000, 4'h2, 1'b0, {4'd11, 4'd0, 4'd12}, "R2 above window");
                send(32'h4000_0010, 4'h7, 1'b1, {4'd11, 4'd1, 4'd12}, "R2 in window after error");
                drain();

                // stall: held word must not move (R7)
                hold_off = 1'b1;
                @(negedge clk);
                send(32'h4ABC_0123, 4'h6, 1'b1, {4'd11, 4'd2, 4'd12}, "R7 held word");
                @(negedge clk); #2;
                check(out_valid, "R9 valid after accept", 32'(out_valid), 32'h1);
                in_addr = 32'h4111_1111; in_priv = 4'hC; in_secure = 1'b0;
                cfg_overlay = {4'd3, 4'd9, 4'd5}; in_valid = 1'b1;
                repeat (3) @(negedge clk);
                #2;
                check(!in_ready, "R7 in_ready low while stalled", 32'(in_ready), 32'h0);
                check(out_word == model(32'h4ABC_0123, 4'h6, 1'b1, {4'd11, 4'd2, 4'd12}),
                      "R7 word stable under stall", out_word,
                      model(32'h4ABC_0123, 4'h6, 1'b1, {4'd11, 4'd2, 4'd12}));
                in_valid = 1'b0;
                hold_off = 1'b0;
                drain();

                // stream with stall rhythm (R8)
                for (int n = 0; n < 24; n++) begin
                    logic [31:0] a;
                    a = {((n % 5 == 4) ? 4'h6 : 4'h4), 28'(32'h0135_79BD * (n + 1))};
                    send(a, 4'(n), n[0], {4'(n % 16), 4'(n % 7), 4'((n * 3) % 16)},
                         "R8 stream order");
                end
                drain();
            end
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule